// File: doc/BRIEF.md
# Receiver Link and Heartbeat Health Monitor

This block watches the health of an event receiver. It raises a sticky link-violation flag when the link layer reports a bit error or a loss of signal. A separate watchdog counts clock cycles since the last heartbeat event code in the received event stream. If that code does not arrive within 1.6 seconds, the watchdog raises a sticky heartbeat-timeout flag.

Each flag has its own interrupt enable bit. The interrupt output is asserted while any flag is set together with its enable. A front-panel error LED output lights while either flag is set.

Software clears a flag by writing 1 to its bit position. Software writes the enable bits through the same small write port. The current flag and enable bits are presented on output ports. Deserialisation and decoding of the link are done upstream of this block.

Top module: `rx_health_mon`

## Requirements
- R1: After reset, both status bits, both enable bits, `irq` and `led_err` are 0, and the heartbeat counter starts from zero.
- R2: A high `link_bit_err` or a high `link_los` at a clock edge sets status bit 0 (link violation), visible after that edge.
- R3: Status bits are sticky. A write with `wr_sel`=0 clears each status bit whose `wr_data` bit is 1. A written 0 leaves the bit unchanged. Bit 0 is the link violation and bit 1 is the heartbeat timeout.
- R4: When a set condition and a write-1 clear of the same status bit meet at one edge, the bit ends up set.
- R5: A write with `wr_sel`=1 loads `wr_data` into the enable register. Bit 0 enables the link-violation interrupt and bit 1 enables the heartbeat-timeout interrupt. The enable value is shown on `irq_en`.
- R6: `irq` is high exactly while some status bit and its enable bit are both 1. It follows the status and enable registers with no further delay.
- R7: `led_err` is high while either status bit is set.
- R8: An edge with `ev_valid`=1 and `ev_code` equal to `HB_CODE` clears the heartbeat counter. The timeout status sets at the TMO-th edge after the last such edge, where TMO is `CLK_HZ`/10×16 cycles (1.6 s). A heartbeat at that very edge prevents the timeout.
- R9: Event codes other than `HB_CODE`, and `HB_CODE` presented with `ev_valid`=0, do not clear the heartbeat counter.
- R10: After a timeout the counter holds at its terminal value. Once cleared, the timeout status stays 0 until a heartbeat arrives and a further full period passes without one.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_bit_err | input | 1 | Link layer reports a bit error this cycle |
| link_los | input | 1 | Link layer reports loss of signal |
| ev_valid | input | 1 | `ev_code` carries a received event this cycle |
| ev_code | input | 8 | Received event code |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = status (write-1-clear), 1 = enable |
| wr_data | input | 2 | Write data, bit 0 link, bit 1 heartbeat |
| status | output | 2 | Sticky flags: bit 0 link violation, bit 1 heartbeat timeout |
| irq_en | output | 2 | Interrupt enable bits |
| irq | output | 1 | Interrupt request |
| led_err | output | 1 | Front-panel error LED drive |

## Verification
The bench builds the block with `CLK_HZ`=100, so the timeout window is 160 cycles and `HB_CODE` is 8'h7A. This brings the exact expiry edge within reach of a cycle-by-cycle sweep of heartbeat gaps around the boundary, from 155 to 166 cycles and also very short gaps. It also allows a pass over every non-heartbeat code during an outage, and observation of the hold-off after a timeout is cleared. The link flag, the set-versus-clear collision and every enable combination are driven directly, and the results are compared with values worked out from the gap length.

// File: rtl/rxh_pkg.sv
package rxh_pkg;
    localparam int N_STAT   = 2;
    localparam int ST_LINK  = 0;
    localparam int ST_HBTO  = 1;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_ENABLE = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/rxh_event_match.sv
module rxh_event_match #(
    parameter int          CODE_W  = 8,
    parameter logic [7:0]  HB_CODE = 8'h7A
) (
    input  logic              ev_valid,
    input  logic [CODE_W-1:0] ev_code,
    output logic              hit
);
    localparam logic [CODE_W-1:0] MATCH = CODE_W'(HB_CODE);

    always_comb begin
        hit = ev_valid && (ev_code == MATCH);
    end
endmodule

// File: rtl/rxh_hb_watchdog.sv
module rxh_hb_watchdog #(
    parameter int TMO   = 160,
    parameter int CNT_W = $clog2(TMO + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hb_hit,
    output logic expire
);
    localparam logic [CNT_W-1:0] TERM = CNT_W'(TMO);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TMO - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } wd_state_t;

    wd_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (hb_hit) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != TERM) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST) begin
                expire = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/rxh_sticky_bits.sv
module rxh_sticky_bits #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic bit_d, bit_q;

        always_comb begin
            bit_d = bit_q;
            if (clr_i[i]) bit_d = 1'b0;
            if (set_i[i]) bit_d = 1'b1;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) bit_q <= 1'b0;
            else        bit_q <= bit_d;
        end

        assign q[i] = bit_q;
    end
endmodule

// File: rtl/rx_health_mon.sv
module rx_health_mon #(
    parameter int          CLK_HZ     = 125_000_000,
    parameter int          TMO_TENTHS = 16,
    parameter int          CODE_W     = 8,
    parameter logic [7:0]  HB_CODE    = 8'h7A
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      link_bit_err,
    input  logic                      link_los,
    input  logic                      ev_valid,
    input  logic [CODE_W-1:0]         ev_code,
    input  logic                      wr_en,
    input  logic                      wr_sel,
    input  logic [rxh_pkg::N_STAT-1:0] wr_data,
    output logic [rxh_pkg::N_STAT-1:0] status,
    output logic [rxh_pkg::N_STAT-1:0] irq_en,
    output logic                      irq,
    output logic                      led_err
);
    import rxh_pkg::*;

    localparam int TMO   = (CLK_HZ / 10) * TMO_TENTHS;
    localparam int CNT_W = $clog2(TMO + 1);

    typedef struct packed {
        logic [N_STAT-1:0] en;
    } cfg_state_t;

    cfg_state_t cfg_d, cfg_q;
    logic hb_hit, expire;
    logic [N_STAT-1:0] set_v, clr_v;

    rxh_event_match #(.CODE_W(CODE_W), .HB_CODE(HB_CODE)) u_match (
        .ev_valid (ev_valid),
        .ev_code  (ev_code),
        .hit      (hb_hit)
    );

    rxh_hb_watchdog #(.TMO(TMO), .CNT_W(CNT_W)) u_wd (
        .clk    (clk),
        .rst_n  (rst_n),
        .hb_hit (hb_hit),
        .expire (expire)
    );

    always_comb begin
        set_v          = '0;
        set_v[ST_LINK] = link_bit_err | link_los;
        set_v[ST_HBTO] = expire;
        clr_v          = (wr_en && reg_sel_e'(wr_sel) == SEL_STATUS) ? wr_data : '0;
        cfg_d          = cfg_q;
        if (wr_en && reg_sel_e'(wr_sel) == SEL_ENABLE) begin
            cfg_d.en = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    rxh_sticky_bits #(.N(N_STAT)) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_v),
        .clr_i (clr_v),
        .q     (status)
    );

    assign irq_en  = cfg_q.en;
    assign irq     = |(status & cfg_q.en);
    assign led_err = |status;
endmodule

// File: rtl/rxh_health_chk.sv
module rxh_health_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       link_bit_err,
    input logic       link_los,
    input logic       hb_hit,
    input logic       wr_en,
    input logic       wr_sel,
    input logic [1:0] wr_data,
    input logic [1:0] status,
    input logic [1:0] irq_en,
    input logic       irq,
    input logic       led_err
);
    // R2: either link fault sets the link flag at the next edge
    a_r2_link_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (link_bit_err || link_los) |=> status[0]);

    // R3: link flag stays until a write-1 clear
    a_r3_sticky_link: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && !(wr_en && !wr_sel && wr_data[0])) |=> status[0]);

    // R3: timeout flag stays until a write-1 clear
    a_r3_sticky_hbto: assert property (@(posedge clk) disable iff (!rst_n)
        (status[1] && !(wr_en && !wr_sel && wr_data[1])) |=> status[1]);

    // R6: an enabled link fault raises the interrupt next cycle
    a_r6_irq_link: assert property (@(posedge clk) disable iff (!rst_n)
        (link_bit_err && irq_en[0] && !(wr_en && wr_sel)) |=> irq);

    // R7: loss of signal lights the LED
    a_r7_led_los: assert property (@(posedge clk) disable iff (!rst_n)
        link_los |=> led_err);

    // R8: a heartbeat edge never coincides with a timeout being raised
    a_r8_hb_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        hb_hit |=> !$rose(status[1]));
endmodule

bind rx_health_mon rxh_health_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .link_bit_err (link_bit_err),
    .link_los     (link_los),
    .hb_hit       (hb_hit),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .wr_data      (wr_data),
    .status       (status),
    .irq_en       (irq_en),
    .irq          (irq),
    .led_err      (led_err)
);

// File: tb/sim_rx_health_mon.sv
module sim_rx_health_mon;
    localparam int         CLK_HZ = 100;
    localparam int         TMO    = (CLK_HZ / 10) * 16;
    localparam logic [7:0] HB     = 8'h7A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       link_bit_err = 1'b0, link_los = 1'b0;
    logic       ev_valid = 1'b0;
    logic [7:0] ev_code = 8'h00;
    logic       wr_en = 1'b0, wr_sel = 1'b0;
    logic [1:0] wr_data = 2'b00;
    logic [1:0] status, irq_en;
    logic       irq, led_err;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rx_health_mon #(.CLK_HZ(CLK_HZ), .HB_CODE(HB)) u0 (
        .clk(clk), .rst_n(rst_n), .link_bit_err(link_bit_err), .link_los(link_los),
        .ev_valid(ev_valid), .ev_code(ev_code), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .status(status), .irq_en(irq_en), .irq(irq), .led_err(led_err)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [1:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 2'b00;
    endtask

    task automatic pulse_hb();
        ev_valid = 1'b1; ev_code = HB;
        @(negedge clk);
        ev_valid = 1'b0; ev_code = 8'h00;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 status", status, 0);
        check("R1 irq_en", irq_en, 0);
        check("R1 irq", irq, 0);
        check("R1 led", led_err, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 status after release", status, 0);

        // link flag: bit error, then loss of signal
        pulse_hb();
        link_bit_err = 1'b1; @(negedge clk); link_bit_err = 1'b0;
        check("R2 bit error sets", status[0], 1);
        check("R7 led on", led_err, 1);
        check("R6 irq off while disabled", irq, 0);
        repeat (5) @(negedge clk);
        check("R3 sticky", status[0], 1);
        wr(1'b0, 2'b10);
        check("R3 write 0 keeps", status[0], 1);
        wr(1'b0, 2'b01);
        check("R3 write 1 clears", status[0], 0);
        check("R7 led off", led_err, 0);
        link_los = 1'b1; @(negedge clk); link_los = 1'b0;
        check("R2 loss of signal sets", status[0], 1);
        link_bit_err = 1'b1; wr_en = 1'b1; wr_sel = 1'b0; wr_data = 2'b01;
        @(negedge clk);
        link_bit_err = 1'b0; wr_en = 1'b0; wr_data = 2'b00;
        check("R4 set wins over clear", status[0], 1);

        // enable sweep on link flag
        for (int e = 0; e < 4; e++) begin
            wr(1'b1, 2'(e));
            check("R5 enable readback", irq_en, e);
            check("R6 irq vs link enable", irq, e & 1);
        end
        wr(1'b0, 2'b11);
        check("R6 irq drops on clear", irq, 0);
        wr(1'b1, 2'b10);

        // exact expiry edge and enabled interrupt
        pulse_hb();
        repeat (TMO - 1) @(negedge clk);
        check("R8 no timeout one edge early", status[1], 0);
        @(negedge clk);
        check("R8 timeout at window edge", status[1], 1);
        check("R6 irq on enabled timeout", irq, 1);
        check("R7 led on timeout", led_err, 1);

        // hold-off after timeout
        wr(1'b0, 2'b10);
        repeat (2 * TMO) @(negedge clk);
        check("R10 timeout raised once per outage", status[1], 0);
        pulse_hb();
        repeat (TMO) @(negedge clk);
        check("R10 rearmed after heartbeat", status[1], 1);
        wr(1'b0, 2'b10);

        // other codes do not clear the counter
        pulse_hb();
        for (int k = 1; k < TMO; k++) begin
            ev_code  = 8'(k % 256);
            ev_valid = (ev_code != HB);
            if (ev_code == HB) ev_valid = 1'b0;
            if (k == 3) begin ev_code = HB; ev_valid = 1'b0; end
            @(negedge clk);
        end
        ev_valid = 1'b0; ev_code = 8'h00;
        check("R9 other codes ignored, before edge", status[1], 0);
        @(negedge clk);
        check("R9 timeout despite other codes", status[1], 1);
        wr(1'b0, 2'b10);

        // gap sweep across the boundary plus short gaps
        for (int g = 1; g <= TMO + 6; g++) begin
            if (g > 4 && g < TMO - 5) continue;
            pulse_hb();
            repeat (g - 1) @(negedge clk);
            pulse_hb();
            check("R8 gap sweep", status[1], (g > TMO) ? 1 : 0);
            wr(1'b0, 2'b10);
        end

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule